// File: doc/BRIEF.md
# Self-Programming Command Control Register

This block is the 8-bit control and status register that a processor core uses to start flash self-programming operations. Software arms a command by writing a legal bit pattern into the low five bits of the register. The next store-to-program-memory instruction then fires the command, provided it arrives within a short window. Each fired command leaves the block as a single-cycle pulse. The pulses go to the flash controller and the page buffer: page erase, page write, buffer fill, lock-bit load, read-while-write section re-enable, and a lock/fuse read request.

The register can be reached over the processor's I/O bus in two ways: by its I/O offset, or by the matching data-space address. The block decodes both itself. If a command is not used before its window closes, the arm bits clear themselves, so a stale command can never fire late. The block also tracks the busy state of the read-while-write section, and it raises an interrupt request whenever interrupts are enabled and no command is armed.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset the register reads 0x00. Bit 5 always reads 0.
- R2: The register is selected at address 0x37 when `busIsData` is 0, and at 0x57 when `busIsData` is 1. A write to any other address changes nothing. A read of any other address returns 0x00.
- R3: Register layout: bit 7 irq enable, bit 6 section busy, bit 5 zero, bit 4 section re-enable, bit 3 lock set, bit 2 page write, bit 1 page erase, bit 0 enable. Bit 7 takes the written value on every selected write. Bit 6 ignores writes. Bits 4:0 are loaded only when the written value is 10001, 01001, 00101, 00011 or 00001; any other value leaves them unchanged.
- R4: A `storeStrobe` sampled on any of the first four clock edges after an arming write fires one single-cycle pulse, in the cycle after that edge. The pulse depends on the armed pattern: 10001 `rwwEnablePulse`, 01001 `lockSetPulse`, 00101 `pageWritePulse`, 00011 `pageErasePulse`, 00001 `bufFillPulse`.
- R5: If no store strobe arrives by the fourth edge after arming, bits 4:0 clear on that edge. A later store strobe gives no pulse.
- R6: When a command fires, bits 4:0 clear on the same edge. This includes the lock-set bit.
- R7: A fired lock-set command presents the `lockData` value sampled at the firing edge on `lockSetData`, together with the pulse.
- R8: With pattern 01001 armed, a `loadStrobe` on one of the first three edges after arming gives `lockFuseRdPulse` in the next cycle. `lockFuseSel` equals the sampled `zBit0` (0 lock bits, 1 fuse bits). A load strobe on the fourth edge gives no read pulse.
- R9: The busy bit (bit 6) sets when a page erase or page write fires. It clears only when a section re-enable fires while `flashBusy` is 0.
- R10: `irqReq` is 1 exactly when bit 7 is 1 and bit 0 is 0.
- R11: A legal write while a window is open restarts the four-edge window. On a legal write, a store strobe sampled on the same edge is ignored.
- R12: A store or load strobe while no command is armed produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Bus address |
| busIsData | input | 1 | 1 when the address is in data space, 0 when it is an I/O offset |
| ioWrEn | input | 1 | Bus write enable |
| ioWrData | input | 8 | Bus write data |
| ioRdData | output | 8 | Register value when the address selects the register, else 0 |
| storeStrobe | input | 1 | Store-to-program-memory instruction executing |
| loadStrobe | input | 1 | Load-from-program-memory instruction executing |
| zBit0 | input | 1 | Bit 0 of the Z pointer |
| lockData | input | 8 | Lock-bit data from R0 |
| flashBusy | input | 1 | Flash controller busy |
| pageErasePulse | output | 1 | Page erase command |
| pageWritePulse | output | 1 | Page write command |
| bufFillPulse | output | 1 | Page buffer fill command |
| lockSetPulse | output | 1 | Lock-bit load command |
| lockSetData | output | 8 | Lock data that goes with `lockSetPulse` |
| rwwEnablePulse | output | 1 | Section re-enable command |
| lockFuseRdPulse | output | 1 | Lock/fuse read request |
| lockFuseSel | output | 1 | 0 lock bits, 1 fuse bits |
| irqReq | output | 1 | Interrupt request |

## Verification
The collision of interest is a register write and a store strobe landing on the same clock edge. A command is armed, and then a second legal pattern is written in the same cycle that a store strobe is driven. The scoreboard must see no pulse for the first command. It must see the second command fire on a strobe one edge later, which shows that the window restarted. A second overlap is also provoked: a load strobe and a store strobe together on the fourth edge in lock mode. Only the lock-set pulse may appear there.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

  typedef enum logic [4:0] {
    PAT_RWW  = 5'b10001,
    PAT_LOCK = 5'b01001,
    PAT_PGWR = 5'b00101,
    PAT_PGER = 5'b00011,
    PAT_FILL = 5'b00001
  } cmdPat_e;

  typedef struct packed {
    logic clearArm;
    logic setBusy;
    logic clearBusy;
  } ctlStrobe_t;

  function automatic logic isLegal(input logic [4:0] pat);
    logic ok;
    case (pat)
      PAT_RWW, PAT_LOCK, PAT_PGWR, PAT_PGER, PAT_FILL: ok = 1'b1;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/selfprog_dp.sv
module selfprog_dp
  import selfprog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IO_OFFSET = 'h37,
  parameter int DATA_BIAS = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busIsData,
  input  logic              ioWrEn,
  input  logic [7:0]        ioWrData,
  input  ctlStrobe_t        ctl,
  output logic [7:0]        ioRdData,
  output logic [4:0]        cmdBits,
  output logic              rwwBusyBit,
  output logic              armWrite,
  output logic              irqReq
);

  localparam logic [ADDR_W-1:0] IO_ADDR   = ADDR_W'(IO_OFFSET);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(IO_OFFSET + DATA_BIAS);

  logic regHit;
  logic wrHit;
  logic irqEnBit;

  assign regHit   = busIsData ? (busAddr == DATA_ADDR) : (busAddr == IO_ADDR);
  assign wrHit    = ioWrEn && regHit;
  assign armWrite = wrHit && isLegal(ioWrData[4:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnBit   <= 1'b0;
      cmdBits    <= '0;
      rwwBusyBit <= 1'b0;
    end else begin
      if (wrHit) irqEnBit <= ioWrData[7];
      if (armWrite)          cmdBits <= ioWrData[4:0];
      else if (ctl.clearArm) cmdBits <= '0;
      if (ctl.setBusy)        rwwBusyBit <= 1'b1;
      else if (ctl.clearBusy) rwwBusyBit <= 1'b0;
    end
  end

  assign ioRdData = regHit ? {irqEnBit, rwwBusyBit, 1'b0, cmdBits} : 8'h00;
  assign irqReq   = irqEnBit && !cmdBits[0];

endmodule

// File: rtl/selfprog_ctl.sv
module selfprog_ctl
  import selfprog_pkg::*;
#(
  parameter int STORE_WIN = 4,
  parameter int LOAD_WIN  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       armWrite,
  input  logic [4:0] cmdBits,
  input  logic       storeStrobe,
  input  logic       loadStrobe,
  input  logic       zBit0,
  input  logic [7:0] lockData,
  input  logic       flashBusy,
  output ctlStrobe_t ctl,
  output logic [4:0] cmdPulse,
  output logic [7:0] lockSetData,
  output logic       lockFuseRdPulse,
  output logic       lockFuseSel
);

  localparam int CNT_W    = $clog2(STORE_WIN + 1);
  localparam int LOAD_MIN = STORE_WIN - LOAD_WIN;
  localparam int NUM_CMD  = 5;
  // pulse index: 0 fill, 1 erase, 2 write, 3 lock, 4 re-enable
  localparam logic [4:0] PAT_TABLE [NUM_CMD] = '{PAT_FILL, PAT_PGER, PAT_PGWR, PAT_LOCK, PAT_RWW};

  logic [CNT_W-1:0]   winCnt;
  logic               live;
  logic               fireStore;
  logic               fireLoad;
  logic [NUM_CMD-1:0] hitVec;

  assign live      = cmdBits[0] && !armWrite;
  assign fireStore = live && storeStrobe;
  assign fireLoad  = live && loadStrobe && (cmdBits == PAT_LOCK) &&
                     (winCnt > CNT_W'(LOAD_MIN));

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_decode
    assign hitVec[g] = fireStore && (cmdBits == PAT_TABLE[g]);
  end

  assign ctl.clearArm  = live && (storeStrobe || (winCnt <= CNT_W'(1)));
  assign ctl.setBusy   = hitVec[1] || hitVec[2];
  assign ctl.clearBusy = hitVec[4] && !flashBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt          <= '0;
      cmdPulse        <= '0;
      lockSetData     <= '0;
      lockFuseRdPulse <= 1'b0;
      lockFuseSel     <= 1'b0;
    end else begin
      if (armWrite)                      winCnt <= CNT_W'(STORE_WIN);
      else if (live && winCnt != '0)     winCnt <= winCnt - CNT_W'(1);
      cmdPulse        <= hitVec;
      lockFuseRdPulse <= fireLoad;
      if (hitVec[3]) lockSetData <= lockData;
      if (fireLoad)  lockFuseSel <= zBit0;
    end
  end

endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
  import selfprog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IO_OFFSET = 'h37,
  parameter int DATA_BIAS = 'h20,
  parameter int STORE_WIN = 4,
  parameter int LOAD_WIN  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busIsData,
  input  logic              ioWrEn,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        ioRdData,
  input  logic              storeStrobe,
  input  logic              loadStrobe,
  input  logic              zBit0,
  input  logic [7:0]        lockData,
  input  logic              flashBusy,
  output logic              pageErasePulse,
  output logic              pageWritePulse,
  output logic              bufFillPulse,
  output logic              lockSetPulse,
  output logic [7:0]        lockSetData,
  output logic              rwwEnablePulse,
  output logic              lockFuseRdPulse,
  output logic              lockFuseSel,
  output logic              irqReq
);

  ctlStrobe_t ctl;
  logic [4:0] cmdBits;
  logic [4:0] cmdPulse;
  logic       rwwBusyBit;
  logic       armWrite;

  selfprog_dp #(
    .ADDR_W(ADDR_W), .IO_OFFSET(IO_OFFSET), .DATA_BIAS(DATA_BIAS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busIsData(busIsData),
    .ioWrEn(ioWrEn), .ioWrData(ioWrData), .ctl(ctl), .ioRdData(ioRdData),
    .cmdBits(cmdBits), .rwwBusyBit(rwwBusyBit), .armWrite(armWrite),
    .irqReq(irqReq)
  );

  selfprog_ctl #(
    .STORE_WIN(STORE_WIN), .LOAD_WIN(LOAD_WIN)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .armWrite(armWrite), .cmdBits(cmdBits),
    .storeStrobe(storeStrobe), .loadStrobe(loadStrobe), .zBit0(zBit0),
    .lockData(lockData), .flashBusy(flashBusy), .ctl(ctl),
    .cmdPulse(cmdPulse), .lockSetData(lockSetData),
    .lockFuseRdPulse(lockFuseRdPulse), .lockFuseSel(lockFuseSel)
  );

  assign bufFillPulse   = cmdPulse[0];
  assign pageErasePulse = cmdPulse[1];
  assign pageWritePulse = cmdPulse[2];
  assign lockSetPulse   = cmdPulse[3];
  assign rwwEnablePulse = cmdPulse[4];

endmodule

// File: rtl/selfprog_chk.sv
module selfprog_chk #(
  parameter int STORE_WIN = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       armWrite,
  input logic [4:0] cmdBits,
  input logic       rwwBusyBit,
  input logic       storeStrobe,
  input logic       flashBusy,
  input logic       irqReq,
  input logic       pageErasePulse,
  input logic       pageWritePulse,
  input logic       bufFillPulse,
  input logic       lockSetPulse,
  input logic       rwwEnablePulse
);

  localparam int AGE_W = $clog2(STORE_WIN + 1) + 1;

  logic [AGE_W-1:0] sinceArm;
  logic             anyPulse;

  assign anyPulse = pageErasePulse || pageWritePulse || bufFillPulse ||
                    lockSetPulse || rwwEnablePulse;

  always_ff @(posedge clk) begin
    if (!rstN)                  sinceArm <= '0;
    else if (armWrite)          sinceArm <= '0;
    else if (cmdBits[0] && sinceArm != '1) sinceArm <= sinceArm + AGE_W'(1);
  end

  p_pulse_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pageErasePulse, pageWritePulse, bufFillPulse, lockSetPulse, rwwEnablePulse}));

  p_window_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdBits[0] |-> (sinceArm < AGE_W'(STORE_WIN)));

  p_fire_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    anyPulse |-> (cmdBits == 5'b0));

  p_busy_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pageErasePulse || pageWritePulse) |-> rwwBusyBit);

  p_busy_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rwwBusyBit) |-> (rwwEnablePulse && !$past(flashBusy)));

  p_irq_armed_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdBits[0]) |-> !irqReq);

  p_idle_stays_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!armWrite && cmdBits == 5'b0) |=> (cmdBits == 5'b0));

  p_no_fire_unarmed_r12: assert property (@(posedge clk) disable iff (!rstN)
    (storeStrobe && !cmdBits[0]) |=> !anyPulse);

endmodule

bind selfprog_ctrl selfprog_chk #(.STORE_WIN(STORE_WIN)) u_chk (
  .clk(clk), .rstN(rstN), .armWrite(armWrite), .cmdBits(cmdBits),
  .rwwBusyBit(rwwBusyBit), .storeStrobe(storeStrobe), .flashBusy(flashBusy),
  .irqReq(irqReq), .pageErasePulse(pageErasePulse),
  .pageWritePulse(pageWritePulse), .bufFillPulse(bufFillPulse),
  .lockSetPulse(lockSetPulse), .rwwEnablePulse(rwwEnablePulse)
);

// File: tb/selfprog_ctrl_tb.sv
module selfprog_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h37;
  logic       busIsData = 1'b0;
  logic       ioWrEn = 1'b0;
  logic [7:0] ioWrData = 8'h00;
  logic [7:0] ioRdData;
  logic       storeStrobe = 1'b0;
  logic       loadStrobe = 1'b0;
  logic       zBit0 = 1'b0;
  logic [7:0] lockData = 8'h00;
  logic       flashBusy = 1'b0;
  logic       pageErasePulse, pageWritePulse, bufFillPulse, lockSetPulse;
  logic [7:0] lockSetData;
  logic       rwwEnablePulse, lockFuseRdPulse, lockFuseSel, irqReq;

  int checkCnt = 0;
  int errCnt = 0;
  bit done = 1'b0;

  // kind bits: 5 re-enable, 4 lock set, 3 page write, 2 page erase, 1 fill, 0 lock/fuse read
  typedef struct packed {
    logic [5:0] kind;
    logic [7:0] data;
    logic       sel;
  } expItem_t;

  expItem_t expQ[$];
  string    reqQ[$];

  always #5 clk = ~clk;

  selfprog_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busIsData(busIsData),
    .ioWrEn(ioWrEn), .ioWrData(ioWrData), .ioRdData(ioRdData),
    .storeStrobe(storeStrobe), .loadStrobe(loadStrobe), .zBit0(zBit0),
    .lockData(lockData), .flashBusy(flashBusy),
    .pageErasePulse(pageErasePulse), .pageWritePulse(pageWritePulse),
    .bufFillPulse(bufFillPulse), .lockSetPulse(lockSetPulse),
    .lockSetData(lockSetData), .rwwEnablePulse(rwwEnablePulse),
    .lockFuseRdPulse(lockFuseRdPulse), .lockFuseSel(lockFuseSel),
    .irqReq(irqReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pushExp(input logic [5:0] kind, input logic [7:0] data,
                         input logic sel, input string req);
    expItem_t it;
    it.kind = kind; it.data = data; it.sel = sel;
    expQ.push_back(it);
    reqQ.push_back(req);
  endtask

  task automatic writeReg(input logic [7:0] addr, input logic isData, input logic [7:0] val);
    busAddr = addr; busIsData = isData; ioWrData = val; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0; busAddr = 8'h37; busIsData = 1'b0; ioWrData = 8'h00;
  endtask

  task automatic readReg(input logic [7:0] addr, input logic isData,
                         input logic [7:0] exp, input string req);
    busAddr = addr; busIsData = isData;
    #1;
    check(req, {24'h0, ioRdData}, {24'h0, exp});
    busAddr = 8'h37; busIsData = 1'b0;
  endtask

  // strobe sampled on the k-th edge from now
  task automatic strobeAt(input int k, input logic st, input logic ld, input logic z);
    repeat (k - 1) @(negedge clk);
    storeStrobe = st; loadStrobe = ld; zBit0 = z;
    @(negedge clk);
    storeStrobe = 1'b0; loadStrobe = 1'b0; zBit0 = 1'b0;
  endtask

  // monitor: pops one expected item for each pulse cycle
  always @(negedge clk) begin
    logic [5:0] seen;
    expItem_t   it;
    string      req;
    if (rstN && !done) begin
      seen = {rwwEnablePulse, lockSetPulse, pageWritePulse, pageErasePulse,
              bufFillPulse, lockFuseRdPulse};
      if (seen != 6'b0) begin
        if (expQ.size() == 0) begin
          checkCnt++; errCnt++;
          $display("FAIL R12: unexpected pulse actual 0x%0h expected 0x0", seen);
        end else begin
          it = expQ.pop_front();
          req = reqQ.pop_front();
          check(req, {26'h0, seen}, {26'h0, it.kind});
          if (it.kind[4]) check({req, " data"}, {24'h0, lockSetData}, {24'h0, it.data});
          if (it.kind[0]) check({req, " sel"}, {31'h0, lockFuseSel}, {31'h0, it.sel});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++; errCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checkCnt, errCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset value
    readReg(8'h37, 1'b0, 8'h00, "R1");
    check("R10 reset irq", {31'h0, irqReq}, 32'h0);

    // R3/R10: illegal low pattern still writes irq enable
    writeReg(8'h37, 1'b0, 8'h80);
    readReg(8'h37, 1'b0, 8'h80, "R3");
    check("R10 irq on", {31'h0, irqReq}, 32'h1);

    // R4 buffer fill on first edge; R10 irq masked while armed
    writeReg(8'h37, 1'b0, 8'h81);
    check("R10 irq armed", {31'h0, irqReq}, 32'h0);
    pushExp(6'b000010, 8'h00, 1'b0, "R4 fill");
    strobeAt(1, 1'b1, 1'b0, 1'b0);
    readReg(8'h37, 1'b0, 8'h80, "R6");
    writeReg(8'h37, 1'b0, 8'h00);
    readReg(8'h37, 1'b0, 8'h00, "R3 irq off");

    // R2 data-space write; R4 erase on fourth edge; R9 busy set
    writeReg(8'h57, 1'b1, 8'h03);
    pushExp(6'b000100, 8'h00, 1'b0, "R4 erase");
    strobeAt(4, 1'b1, 1'b0, 1'b0);
    readReg(8'h57, 1'b1, 8'h40, "R9 busy set");

    // R2 other addresses
    writeReg(8'h38, 1'b0, 8'h05);
    readReg(8'h37, 1'b0, 8'h40, "R2 no write");
    readReg(8'h38, 1'b0, 8'h00, "R2 read other");
    readReg(8'h37, 1'b1, 8'h00, "R2 data 0x37");

    // R3 busy read-only; R5 expiry, late strobe ignored
    writeReg(8'h37, 1'b0, 8'h05);
    readReg(8'h37, 1'b0, 8'h45, "R3 busy ro");
    strobeAt(5, 1'b1, 1'b0, 1'b0);
    readReg(8'h37, 1'b0, 8'h40, "R5");

    // R3 illegal patterns
    writeReg(8'h37, 1'b0, 8'h07);
    readReg(8'h37, 1'b0, 8'h40, "R3 illegal");
    writeReg(8'h37, 1'b0, 8'hFF);
    readReg(8'h37, 1'b0, 8'hC0, "R1 bit5");
    writeReg(8'h37, 1'b0, 8'h00);

    // R9 re-enable while flash busy keeps busy
    flashBusy = 1'b1;
    writeReg(8'h37, 1'b0, 8'h11);
    readReg(8'h37, 1'b0, 8'h51, "R3 arm rww");
    pushExp(6'b100000, 8'h00, 1'b0, "R4 rww");
    strobeAt(2, 1'b1, 1'b0, 1'b0);
    readReg(8'h37, 1'b0, 8'h40, "R9 busy held");
    flashBusy = 1'b0;
    writeReg(8'h37, 1'b0, 8'h11);
    pushExp(6'b100000, 8'h00, 1'b0, "R9 rww");
    strobeAt(1, 1'b1, 1'b0, 1'b0);
    readReg(8'h37, 1'b0, 8'h00, "R9 busy clear");

    // R8 load on third edge, R7 lock set on fourth
    lockData = 8'hA5;
    writeReg(8'h37, 1'b0, 8'h09);
    pushExp(6'b000001, 8'h00, 1'b1, "R8 fuse read");
    strobeAt(3, 1'b0, 1'b1, 1'b1);
    pushExp(6'b010000, 8'hA5, 1'b0, "R7 lock set");
    strobeAt(1, 1'b1, 1'b0, 1'b0);
    readReg(8'h37, 1'b0, 8'h00, "R6 lock clear");

    // R8 load on fourth edge gives no read; store still fires
    lockData = 8'h3C;
    writeReg(8'h37, 1'b0, 8'h09);
    pushExp(6'b010000, 8'h3C, 1'b0, "R8 late load");
    strobeAt(4, 1'b1, 1'b1, 1'b0);
    readReg(8'h37, 1'b0, 8'h00, "R6");

    // R11 re-arm restarts window
    writeReg(8'h37, 1'b0, 8'h05);
    repeat (2) @(negedge clk);
    writeReg(8'h37, 1'b0, 8'h05);
    pushExp(6'b001000, 8'h00, 1'b0, "R11 rearm");
    strobeAt(4, 1'b1, 1'b0, 1'b0);
    readReg(8'h37, 1'b0, 8'h40, "R9 write busy");

    // R11 write and strobe on the same edge
    writeReg(8'h37, 1'b0, 8'h01);
    busAddr = 8'h37; ioWrData = 8'h03; ioWrEn = 1'b1; storeStrobe = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0; ioWrData = 8'h00; storeStrobe = 1'b0;
    readReg(8'h37, 1'b0, 8'h43, "R11 collision");
    pushExp(6'b000100, 8'h00, 1'b0, "R11 erase");
    strobeAt(1, 1'b1, 1'b0, 1'b0);

    // R12 strobes while idle
    strobeAt(1, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    readReg(8'h37, 1'b0, 8'h40, "R12 idle");

    check("R4 queue drained", expQ.size(), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checkCnt, errCnt);
    $finish;
  end

endmodule